// File: doc/BRIEF.md
# RV32I Instruction Decode Unit

This block turns one 32-bit RV32I instruction word into the control and operand information that a single-cycle core needs in the same cycle. The outputs are the three register addresses, a sign-extended immediate, an operation class, the register write enable, the memory read and write enables, and two ALU operand-source selects. The first select picks the instruction address or register data for operand 1. The second picks the immediate or register data for operand 2. The decoder covers register-register arithmetic, immediate arithmetic including shifts, loads, stores, branches, LUI, AUIPC, JAL and JALR.

The decode path is purely combinational. The instruction enters on a valid/ready stream, and the decoded bundle leaves on a second valid/ready stream within the same cycle. The block holds no storage, so back-pressure passes straight through. The upstream ready equals the downstream ready, and the downstream valid equals the upstream valid. While the downstream side stalls, the upstream side must keep the instruction word steady if the decoded bundle is to stay steady. The clock and reset pins serve only the built-in property checks.

Top module: `rvdec_top`

## Requirements
- R1: Fields are taken from fixed bit positions: opcode instr[6:0], rd instr[11:7], funct3 instr[14:12], rs1 instr[19:15], rs2 instr[24:20], and the funct7 alternate bit instr[30].
- R2: `op_class` encodes the opcode as follows: 0 unrecognised, 1 register arithmetic (0110011), 2 immediate arithmetic (0010011), 3 load (0000011), 4 store (0100011), 5 branch (1100011), 6 LUI (0110111), 7 AUIPC (0010111), 8 JAL (1101111), 9 JALR (1100111).
- R3: A store asserts `mem_we` and deasserts `reg_we` and `mem_re`. Its immediate is {instr[31:25], instr[11:7]}, sign-extended from bit 31.
- R4: A load asserts `mem_re` and `reg_we` and deasserts `mem_we`. Its immediate is instr[31:20], sign-extended.
- R5: Register arithmetic asserts `reg_we` and neither memory enable, selects register data for both operands, and drives `alu_alt` with instr[30] (1 selects subtract or arithmetic right shift).
- R6: For immediate arithmetic with funct3 001 or 101, the immediate is the zero-extended instr[24:20], and `alu_alt` is instr[30] only when funct3 is 101. For all other immediate arithmetic, the immediate is the sign-extended instr[31:20] and `alu_alt` is 0.
- R7: LUI and AUIPC produce the immediate {instr[31:12], 12'b0} with `reg_we`=1 and `op2_sel`=1. LUI uses `op1_sel`=0, so operand 1 is register x0. AUIPC uses `op1_sel`=1.
- R8: A branch produces the immediate {instr[31], instr[7], instr[30:25], instr[11:8], 0}, sign-extended, with `op1_sel`=1, `op2_sel`=1, `reg_we`=0 and no memory enable.
- R9: JAL produces the immediate {instr[31], instr[19:12], instr[20], instr[30:21], 0}, sign-extended, with `op1_sel`=1, `op2_sel`=1 and `reg_we`=1. JALR uses the I immediate with `op1_sel`=0, `op2_sel`=1 and `reg_we`=1.
- R10: Register addresses that a class does not use are driven to 0. Register arithmetic uses rs1, rs2 and rd. Immediate arithmetic, loads and JALR use rs1 and rd. Stores and branches use rs1 and rs2. LUI, AUIPC and JAL use rd only. `funct3` is driven to 0 for LUI, AUIPC and JAL.
- R11: An unrecognised opcode drives `op_class`, all enables, selects, addresses, `funct3`, `alu_alt` and `imm` to 0.
- R12: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle. Decoding does not depend on either handshake signal.
- R13: `op1_sel` 0 means register data and 1 means the instruction address. `op2_sel` 0 means register data and 1 means the immediate. Whenever `op1_sel` is 1, `op2_sel` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in property checks |
| rst_n | input | 1 | Active-low reset that disables the property checks |
| in_valid | input | 1 | Instruction word is offered |
| in_ready | output | 1 | Decoder can take the word (follows out_ready) |
| instr | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded bundle is valid |
| out_ready | input | 1 | Consumer takes the bundle |
| op_class | output | 4 | Operation class code |
| rs1_addr | output | 5 | Source register 1 address |
| rs2_addr | output | 5 | Source register 2 address |
| rd_addr | output | 5 | Destination register address |
| imm | output | 32 | Sign-extended immediate |
| funct3 | output | 3 | Sub-operation field |
| alu_alt | output | 1 | Alternate ALU operation (subtract or arithmetic shift) |
| op1_sel | output | 1 | Operand 1 source: 0 register, 1 instruction address |
| op2_sel | output | 1 | Operand 2 source: 0 register, 1 immediate |
| reg_we | output | 1 | Register file write enable |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |

## Verification
The first set of inputs is hand-encoded words: a store with a positive offset, a subtract, slli and srai, LUI, a negative addi, a backward branch, a forward JAL, a load and two unrecognised opcodes. These pin each immediate layout and enable pattern to a known number, and they separate subtract and arithmetic shift from add and logical shift. The second set is random words whose opcode is forced into one of the supported classes or an illegal value, so every scattered immediate bit and sign combination is tried, including addi words with bit 30 set, which must not raise the alternate flag. Random valid and ready values run alongside the words to show that the handshake never alters the decoded bundle.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned OPC_W  = 7;
  localparam int unsigned CLS_W  = 4;

  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE   = 4'd0,
    CLS_ALUREG = 4'd1,
    CLS_ALUIMM = 4'd2,
    CLS_LOAD   = 4'd3,
    CLS_STORE  = 4'd4,
    CLS_BRANCH = 4'd5,
    CLS_LUI    = 4'd6,
    CLS_AUIPC  = 4'd7,
    CLS_JAL    = 4'd8,
    CLS_JALR   = 4'd9
  } op_class_e;

  typedef enum logic [2:0] {
    FMT_NONE, FMT_I, FMT_SH, FMT_S, FMT_B, FMT_U, FMT_J
  } imm_fmt_e;

  typedef struct packed {
    op_class_e cls;
    imm_fmt_e  fmt;
    logic      use_rs1;
    logic      use_rs2;
    logic      use_rd;
    logic      use_f3;
    logic      alt;
    logic      op1_pc;
    logic      op2_imm;
    logic      reg_we;
    logic      mem_re;
    logic      mem_we;
  } dec_ctl_t;
endpackage

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [2:0]       f3,
  input  logic             bit30,
  output dec_ctl_t         ctl
);
  always_comb begin
    ctl = '0;
    ctl.cls = CLS_NONE;
    ctl.fmt = FMT_NONE;
    unique case (opcode)
      OPC_OP: begin
        ctl.cls = CLS_ALUREG;
        ctl.use_rs1 = 1'b1; ctl.use_rs2 = 1'b1; ctl.use_rd = 1'b1;
        ctl.use_f3 = 1'b1; ctl.alt = bit30; ctl.reg_we = 1'b1;
      end
      OPC_OPIMM: begin
        ctl.cls = CLS_ALUIMM;
        ctl.use_rs1 = 1'b1; ctl.use_rd = 1'b1; ctl.use_f3 = 1'b1;
        ctl.op2_imm = 1'b1; ctl.reg_we = 1'b1;
        if (f3 == 3'b001 || f3 == 3'b101) begin
          ctl.fmt = FMT_SH;
          ctl.alt = (f3 == 3'b101) ? bit30 : 1'b0;
        end else begin
          ctl.fmt = FMT_I;
        end
      end
      OPC_LOAD: begin
        ctl.cls = CLS_LOAD; ctl.fmt = FMT_I;
        ctl.use_rs1 = 1'b1; ctl.use_rd = 1'b1; ctl.use_f3 = 1'b1;
        ctl.op2_imm = 1'b1; ctl.reg_we = 1'b1; ctl.mem_re = 1'b1;
      end
      OPC_STORE: begin
        ctl.cls = CLS_STORE; ctl.fmt = FMT_S;
        ctl.use_rs1 = 1'b1; ctl.use_rs2 = 1'b1; ctl.use_f3 = 1'b1;
        ctl.op2_imm = 1'b1; ctl.mem_we = 1'b1;
      end
      OPC_BRANCH: begin
        ctl.cls = CLS_BRANCH; ctl.fmt = FMT_B;
        ctl.use_rs1 = 1'b1; ctl.use_rs2 = 1'b1; ctl.use_f3 = 1'b1;
        ctl.op1_pc = 1'b1; ctl.op2_imm = 1'b1;
      end
      OPC_LUI: begin
        ctl.cls = CLS_LUI; ctl.fmt = FMT_U;
        ctl.use_rd = 1'b1; ctl.op2_imm = 1'b1; ctl.reg_we = 1'b1;
      end
      OPC_AUIPC: begin
        ctl.cls = CLS_AUIPC; ctl.fmt = FMT_U;
        ctl.use_rd = 1'b1; ctl.op1_pc = 1'b1; ctl.op2_imm = 1'b1;
        ctl.reg_we = 1'b1;
      end
      OPC_JAL: begin
        ctl.cls = CLS_JAL; ctl.fmt = FMT_J;
        ctl.use_rd = 1'b1; ctl.op1_pc = 1'b1; ctl.op2_imm = 1'b1;
        ctl.reg_we = 1'b1;
      end
      OPC_JALR: begin
        ctl.cls = CLS_JALR; ctl.fmt = FMT_I;
        ctl.use_rs1 = 1'b1; ctl.use_rd = 1'b1; ctl.use_f3 = 1'b1;
        ctl.op2_imm = 1'b1; ctl.reg_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rvdec_imm.sv
module rvdec_imm
  import rvdec_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:7] ibits,
  input  imm_fmt_e     fmt,
  output logic [W-1:0] imm
);
  localparam int unsigned SH_W = $clog2(W);
  logic sgn;
  assign sgn = ibits[W-1];

  always_comb begin
    unique case (fmt)
      FMT_I:  imm = {{(W-12){sgn}}, ibits[W-1:20]};
      FMT_SH: imm = {{(W-SH_W){1'b0}}, ibits[20+SH_W-1:20]};
      FMT_S:  imm = {{(W-12){sgn}}, ibits[W-1:25], ibits[11:7]};
      FMT_B:  imm = {{(W-12){sgn}}, ibits[7], ibits[30:25], ibits[11:8], 1'b0};
      FMT_U:  imm = {ibits[W-1:12], 12'b0};
      FMT_J:  imm = {{(W-20){sgn}}, ibits[19:12], ibits[20], ibits[30:21], 1'b0};
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/rvdec_regsel.sv
module rvdec_regsel
  import rvdec_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] rs1_f,
  input  logic [AW-1:0] rs2_f,
  input  logic [AW-1:0] rd_f,
  input  logic [2:0]    f3_f,
  input  logic          use_rs1,
  input  logic          use_rs2,
  input  logic          use_rd,
  input  logic          use_f3,
  output logic [AW-1:0] rs1_o,
  output logic [AW-1:0] rs2_o,
  output logic [AW-1:0] rd_o,
  output logic [2:0]    f3_o
);
  assign rs1_o = use_rs1 ? rs1_f : '0;
  assign rs2_o = use_rs2 ? rs2_f : '0;
  assign rd_o  = use_rd  ? rd_f  : '0;
  assign f3_o  = use_f3  ? f3_f  : '0;
endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
  import rvdec_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  instr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [3:0]    op_class,
  output logic [AW-1:0] rs1_addr,
  output logic [AW-1:0] rs2_addr,
  output logic [AW-1:0] rd_addr,
  output logic [W-1:0]  imm,
  output logic [2:0]    funct3,
  output logic          alu_alt,
  output logic          op1_sel,
  output logic          op2_sel,
  output logic          reg_we,
  output logic          mem_re,
  output logic          mem_we
);
  localparam int unsigned SH_W = $clog2(W);

  dec_ctl_t ctl;

  // no storage: handshake passes straight through
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  rvdec_ctrl u_ctrl (
    .opcode(instr[6:0]),
    .f3    (instr[14:12]),
    .bit30 (instr[30]),
    .ctl   (ctl)
  );

  rvdec_imm #(.W(W)) u_imm (
    .ibits(instr[W-1:7]),
    .fmt  (ctl.fmt),
    .imm  (imm)
  );

  rvdec_regsel #(.AW(AW)) u_regsel (
    .rs1_f  (instr[15+AW-1:15]),
    .rs2_f  (instr[20+AW-1:20]),
    .rd_f   (instr[7+AW-1:7]),
    .f3_f   (instr[14:12]),
    .use_rs1(ctl.use_rs1),
    .use_rs2(ctl.use_rs2),
    .use_rd (ctl.use_rd),
    .use_f3 (ctl.use_f3),
    .rs1_o  (rs1_addr),
    .rs2_o  (rs2_addr),
    .rd_o   (rd_addr),
    .f3_o   (funct3)
  );

  assign op_class = ctl.cls;
  assign alu_alt  = ctl.alt;
  assign op1_sel  = ctl.op1_pc;
  assign op2_sel  = ctl.op2_imm;
  assign reg_we   = ctl.reg_we;
  assign mem_re   = ctl.mem_re;
  assign mem_we   = ctl.mem_we;

  // R3: a store never writes the register file and names no destination
  a_r3_store_no_regwrite: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!reg_we && rd_addr == '0));

  // R4: memory read and write are never raised together
  a_r4_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re, mem_we}));

  // R6: shift amounts never carry bits above the shift width
  a_r6_shamt_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == CLS_ALUIMM && instr[13:12] == 2'b01) |-> (imm[W-1:SH_W] == '0));

  // R8: branch and jump offsets are always even
  a_r8_target_even: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == CLS_BRANCH || op_class == CLS_JAL) |-> !imm[0]);

  // R10: no destination is named when nothing is written
  a_r10_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |-> (rd_addr == '0));

  // R11: an unrecognised opcode is fully quiet
  a_r11_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == CLS_NONE) |-> (!reg_we && !mem_re && !mem_we && imm == '0));

  // R13: the instruction address is only paired with the immediate
  a_r13_pc_with_imm: assert property (@(posedge clk) disable iff (!rst_n)
    op1_sel |-> op2_sel);
endmodule

// File: tb/rvdec_top_test.sv
module rvdec_top_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [31:0] instr, imm;
  logic [3:0]  op_class;
  logic [4:0]  rs1_addr, rs2_addr, rd_addr;
  logic [2:0]  funct3;
  logic        alu_alt, op1_sel, op2_sel, reg_we, mem_re, mem_we;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  rvdec_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .out_valid(out_valid), .out_ready(out_ready),
    .op_class(op_class), .rs1_addr(rs1_addr), .rs2_addr(rs2_addr),
    .rd_addr(rd_addr), .imm(imm), .funct3(funct3), .alu_alt(alu_alt),
    .op1_sel(op1_sel), .op2_sel(op2_sel), .reg_we(reg_we),
    .mem_re(mem_re), .mem_we(mem_we)
  );

  typedef struct packed {
    logic [3:0]  cls;
    logic [4:0]  rs1, rs2, rd;
    logic [31:0] imm;
    logic [2:0]  f3;
    logic        alt, s1, s2, we, re, me;
  } exp_t;

  function automatic exp_t ref_dec(input logic [31:0] w);
    exp_t e;
    logic [12:0] b;
    logic [20:0] j;
    e = '0;
    b = {w[31], w[7], w[30:25], w[11:8], 1'b0};
    j = {w[31], w[19:12], w[20], w[30:21], 1'b0};
    case (w[6:0])
      7'h33: begin e.cls = 1; e.rs1 = w[19:15]; e.rs2 = w[24:20]; e.rd = w[11:7];
        e.f3 = w[14:12]; e.alt = w[30]; e.we = 1; end
      7'h13: begin e.cls = 2; e.rs1 = w[19:15]; e.rd = w[11:7]; e.f3 = w[14:12];
        e.s2 = 1; e.we = 1;
        if (w[13:12] == 2'b01) begin
          e.imm = {27'd0, w[24:20]};
          e.alt = w[14] ? w[30] : 1'b0;
        end else e.imm = $signed(w) >>> 20;
      end
      7'h03: begin e.cls = 3; e.rs1 = w[19:15]; e.rd = w[11:7]; e.f3 = w[14:12];
        e.s2 = 1; e.we = 1; e.re = 1; e.imm = $signed(w) >>> 20; end
      7'h23: begin e.cls = 4; e.rs1 = w[19:15]; e.rs2 = w[24:20]; e.f3 = w[14:12];
        e.s2 = 1; e.me = 1; e.imm = $signed({w[31:25], w[11:7], 20'd0}) >>> 20; end
      7'h63: begin e.cls = 5; e.rs1 = w[19:15]; e.rs2 = w[24:20]; e.f3 = w[14:12];
        e.s1 = 1; e.s2 = 1; e.imm = $signed({b, 19'd0}) >>> 19; end
      7'h37: begin e.cls = 6; e.rd = w[11:7]; e.s2 = 1; e.we = 1;
        e.imm = {w[31:12], 12'd0}; end
      7'h17: begin e.cls = 7; e.rd = w[11:7]; e.s1 = 1; e.s2 = 1; e.we = 1;
        e.imm = {w[31:12], 12'd0}; end
      7'h6F: begin e.cls = 8; e.rd = w[11:7]; e.s1 = 1; e.s2 = 1; e.we = 1;
        e.imm = $signed({j, 11'd0}) >>> 11; end
      7'h67: begin e.cls = 9; e.rs1 = w[19:15]; e.rd = w[11:7]; e.f3 = w[14:12];
        e.s2 = 1; e.we = 1; e.imm = $signed(w) >>> 20; end
      default: ;
    endcase
    return e;
  endfunction

  function automatic string cls_tag(input logic [3:0] c);
    case (c)
      1: return "R5";  2: return "R6";  3: return "R4";  4: return "R3";
      5: return "R8";  6, 7: return "R7"; 8, 9: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (instr %h)", tag, got, exp, instr);
    end
  endtask

  task automatic compare_all();
    exp_t e;
    string t;
    e = ref_dec(instr);
    t = cls_tag(e.cls);
    chk("R2 class", 32'(op_class), 32'(e.cls));
    chk("R1 rs1 / R10", 32'(rs1_addr), 32'(e.rs1));
    chk("R1 rs2 / R10", 32'(rs2_addr), 32'(e.rs2));
    chk("R1 rd / R10", 32'(rd_addr), 32'(e.rd));
    chk({t, " imm"}, imm, e.imm);
    chk({t, " funct3"}, 32'(funct3), 32'(e.f3));
    chk({t, " alt"}, 32'(alu_alt), 32'(e.alt));
    chk({t, " enables"}, 32'({reg_we, mem_re, mem_we}), 32'({e.we, e.re, e.me}));
    chk("R13 selects", 32'({op1_sel, op2_sel}), 32'({e.s1, e.s2}));
    chk("R12 handshake", 32'({out_valid, in_ready}), 32'({in_valid, out_ready}));
  endtask

  task automatic apply(input logic [31:0] w, input logic v, input logic r);
    @(posedge clk); #1;
    instr = w; in_valid = v; out_ready = r;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; instr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: instruction zero is an unrecognised opcode
    chk("R11 reset quiet", {op_class, reg_we, mem_re, mem_we, op1_sel, op2_sel, imm[22:0]}, '0);
    @(posedge clk); #1; rst_n = 1'b1;

    apply(32'h01612E23, 1, 1); // sw x22, 28(x2)
    chk("R3 sw imm", imm, 32'd28);
    chk("R3 sw mem_we", {31'd0, mem_we & ~reg_we}, 32'd1);
    chk("R1 sw rs2", 32'(rs2_addr), 32'd22);
    apply(32'h40830333, 1, 0); // sub x6, x6, x8
    chk("R5 sub alt", 32'(alu_alt), 32'd1);
    chk("R1 sub rs2", 32'(rs2_addr), 32'd8);
    apply(32'h00231313, 0, 1); // slli x6, x6, 2
    chk("R6 slli imm", imm, 32'd2);
    apply(32'h40525193, 1, 1); // srai x3, x4, 5
    chk("R6 srai alt", 32'({alu_alt, imm[4:0]}), 32'h25);
    apply(32'hFFF00093, 1, 1); // addi x1, x0, -1
    chk("R6 addi neg imm", imm, 32'hFFFFFFFF);
    chk("R6 addi alt", 32'(alu_alt), 32'd0);
    apply(32'h000022B7, 1, 1); // lui x5, 2
    chk("R7 lui imm", imm, 32'h00002000);
    chk("R10 lui rs1", 32'(rs1_addr), 32'd0);
    apply(32'hFE000EE3, 1, 1); // beq x0, x0, -4
    chk("R8 beq imm", imm, 32'hFFFFFFFC);
    apply(32'h008000EF, 1, 1); // jal x1, 8
    chk("R9 jal imm", imm, 32'd8);
    chk("R9 jal rd", 32'(rd_addr), 32'd1);
    apply(32'h00032583, 1, 1); // lw x11, 0(x6)
    chk("R4 lw enables", 32'({reg_we, mem_re, mem_we}), 32'b110);
    apply(32'h0000000B, 1, 1);
    chk("R11 custom opcode", {op_class, reg_we, mem_re, mem_we, imm[24:0]}, '0);
    apply(32'hFFFFFFFF, 1, 1);
    chk("R11 all ones", {imm, 25'd0, rs1_addr, op_class[0], reg_we}, '0);

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] w;
      logic [6:0] opc;
      w = $urandom;
      case ($urandom_range(0, 10))
        0: opc = 7'h33; 1: opc = 7'h13; 2: opc = 7'h03; 3: opc = 7'h23;
        4: opc = 7'h63; 5: opc = 7'h37; 6: opc = 7'h17; 7: opc = 7'h6F;
        8: opc = 7'h67; 9: opc = 7'h13; default: opc = w[6:0];
      endcase
      apply({w[31:7], opc}, 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule